// File: doc/BRIEF.md
# Ring Column Dispatch Steering Unit

This block sits at the dispatch stage of a core built from several execution columns joined in a one-way ring. Each column owns an equal, contiguous bank of physical registers, a slice of the issue window and one ALU. For each renamed instruction the block picks the column it will run in and allocates the destination physical register from that column's bank. An instruction can then write back only into its own column's bank.

Steering follows data dependence. A slice of the issue window can hold only one pending source tag. An instruction that still waits on one operand is therefore forced into the column that follows the producer's column in the ring, which is where that producer's result is forwarded. An instruction whose operands are all ready may go to any column, and a round-robin pointer spreads these instructions across the columns. An instruction waiting on two operands cannot be placed, so it stalls. A placement also stalls when the required column has no free register or a full window slice. The producer column of a source is the bank that holds the source's physical tag. Registers that are released come back through a return port and go to the bank that their tag falls in.

Top module: `col_steer`

## Requirements
- R1: A physical tag is `{column, local index}`. The upper `$clog2(NUM_COLS)` bits give the bank and the lower `$clog2(REGS_PER_COL)` bits give the slot. Every allocated destination lies in the bank of the column reported on `disp_col_o`.
- R2: If exactly one source is not ready, the instruction goes to column `(bank(tag)+1) mod NUM_COLS`, where `tag` is the physical tag of the waiting source. Column 3 wraps to column 0.
- R3: If both sources are not ready (`src_rdy_i == 2'b00`), `stall_o` is high, `disp_fire_o` is low and no register is allocated.
- R4: If both sources are ready, the block takes the first column, starting at the round-robin pointer, that has a free register and a clear `win_full_i` bit. After such a dispatch the pointer moves to the column after the one chosen. Dependent dispatches leave the pointer unchanged. If no column qualifies, the instruction stalls.
- R5: If the required column has an empty free list or a set `win_full_i` bit, `stall_o` is high, `disp_fire_o` is low and nothing is allocated.
- R6: A tag returned on `free_tag_i` is appended to the free list of bank `free_tag_i / REGS_PER_COL`. Each bank hands out registers in first-in, first-out order. A return in the same cycle as a stall does not make that stall dispatch.
- R7: After reset every bank is full and hands out its slots in ascending order, starting at slot 0. The round-robin pointer starts at column 0. At most one register is allocated per cycle, and the allocation takes effect on the same clock edge as the dispatch.
- R8: `wait_valid_o` is high exactly when a valid request has one waiting source. `wait_tag_o` then carries that source's tag.
- R9: When `disp_valid_i` is low, `disp_fire_o` and `stall_o` are both low and no register is allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Renamed instruction present |
| src_rdy_i | input | 2 | Ready flag for each source; bit 0 is source 0 |
| src0_tag_i | input | TAG_W | Physical tag of source 0 |
| src1_tag_i | input | TAG_W | Physical tag of source 1 |
| win_full_i | input | NUM_COLS | Issue window slice full, one bit per column |
| free_valid_i | input | 1 | A released register is returned |
| free_tag_i | input | TAG_W | Tag of the released register |
| disp_fire_o | output | 1 | Instruction dispatched this cycle |
| stall_o | output | 1 | Instruction held this cycle |
| disp_col_o | output | COL_W | Chosen column |
| disp_dst_o | output | TAG_W | Allocated destination tag |
| wait_valid_o | output | 1 | Instruction carries one waiting source |
| wait_tag_o | output | TAG_W | Tag of the waiting source |

## Verification
On every cycle the checker confirms the following:
- an allocated tag lies in the chosen bank;
- a dependent dispatch lands one column after its producer;
- two waiting sources, or an idle request, never fire;
- no dispatch goes into a full window slice;
- the wait tag matches the source that is not ready;
- fire and stall are never high together.

The round-robin order, the first-in first-out order of each bank, the return of a freed tag to the correct bank, and the stall on an exhausted bank depend on state built up over many cycles. Only the bench scenarios show these, by tracking the sequence of allocated tags.

// File: rtl/steer_pkg.sv
package steer_pkg;
  typedef enum logic [1:0] {
    KIND_READY = 2'd0,
    KIND_DEP   = 2'd1,
    KIND_BAD   = 2'd2
  } req_kind_e;
endpackage

// File: rtl/steer_free_list.sv
module steer_free_list #(
  parameter int REGS_PER_COL = 8,
  localparam int LW = $clog2(REGS_PER_COL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pop_i,
  input  logic          push_i,
  input  logic [LW-1:0] push_idx_i,
  output logic          empty_o,
  output logic [LW-1:0] head_o,
  output logic [LW:0]   cnt_o
);
  logic [LW-1:0] mem_q [REGS_PER_COL];
  logic [LW-1:0] head_q, tail_q;
  logic [LW:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < REGS_PER_COL; i++) mem_q[i] <= LW'(i);
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= (LW+1)'(REGS_PER_COL);
    end else begin
      if (push_i) begin
        mem_q[tail_q] <= push_idx_i;
        tail_q        <= tail_q + 1'b1;
      end
      if (pop_i) head_q <= head_q + 1'b1;
      cnt_q <= cnt_q + (LW+1)'(push_i) - (LW+1)'(pop_i);
    end
  end

  assign empty_o = (cnt_q == '0);
  assign head_o  = mem_q[head_q];
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/steer_rr_pick.sv
module steer_rr_pick #(
  parameter int NUM_COLS = 4,
  localparam int CW = $clog2(NUM_COLS)
) (
  input  logic [NUM_COLS-1:0] avail_i,
  input  logic [CW-1:0]       start_i,
  output logic                found_o,
  output logic [CW-1:0]       pick_o
);
  always_comb begin
    found_o = 1'b0;
    pick_o  = start_i;
    // descending scan: the smallest offset from start wins
    for (int k = NUM_COLS - 1; k >= 0; k--) begin
      int s;
      s = int'(start_i) + k;
      if (s >= NUM_COLS) s = s - NUM_COLS;
      if (avail_i[s]) begin
        found_o = 1'b1;
        pick_o  = CW'(s);
      end
    end
  end
endmodule

// File: rtl/steer_classify.sv
module steer_classify
  import steer_pkg::*;
#(
  parameter int NUM_COLS     = 4,
  parameter int REGS_PER_COL = 8,
  localparam int CW = $clog2(NUM_COLS),
  localparam int LW = $clog2(REGS_PER_COL),
  localparam int TW = CW + LW
) (
  input  logic [1:0]    src_rdy_i,
  input  logic [TW-1:0] src0_tag_i,
  input  logic [TW-1:0] src1_tag_i,
  output req_kind_e     kind_o,
  output logic [TW-1:0] wait_tag_o,
  output logic [CW-1:0] dep_col_o
);
  logic [CW-1:0] prod_col;

  always_comb begin
    unique case (src_rdy_i)
      2'b11:   begin kind_o = KIND_READY; wait_tag_o = '0;         end
      2'b10:   begin kind_o = KIND_DEP;   wait_tag_o = src0_tag_i; end
      2'b01:   begin kind_o = KIND_DEP;   wait_tag_o = src1_tag_i; end
      default: begin kind_o = KIND_BAD;   wait_tag_o = '0;         end
    endcase
  end

  assign prod_col  = wait_tag_o[TW-1:LW];
  assign dep_col_o = (int'(prod_col) == NUM_COLS - 1) ? '0 : prod_col + 1'b1;
endmodule

// File: rtl/col_steer.sv
module col_steer
  import steer_pkg::*;
#(
  parameter int NUM_COLS     = 4,
  parameter int REGS_PER_COL = 8,
  localparam int COL_W = $clog2(NUM_COLS),
  localparam int LW    = $clog2(REGS_PER_COL),
  localparam int TAG_W = COL_W + LW
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                disp_valid_i,
  input  logic [1:0]          src_rdy_i,
  input  logic [TAG_W-1:0]    src0_tag_i,
  input  logic [TAG_W-1:0]    src1_tag_i,
  input  logic [NUM_COLS-1:0] win_full_i,
  input  logic                free_valid_i,
  input  logic [TAG_W-1:0]    free_tag_i,
  output logic                disp_fire_o,
  output logic                stall_o,
  output logic [COL_W-1:0]    disp_col_o,
  output logic [TAG_W-1:0]    disp_dst_o,
  output logic                wait_valid_o,
  output logic [TAG_W-1:0]    wait_tag_o
);
  req_kind_e           kind;
  logic [COL_W-1:0]    dep_col, rr_pick, rr_q, col;
  logic                rr_found, ok;
  logic [NUM_COLS-1:0] empty, avail, pop, push;
  logic [LW-1:0]       head_all [NUM_COLS];
  logic [LW:0]         cnt_all  [NUM_COLS];

  steer_classify #(.NUM_COLS(NUM_COLS), .REGS_PER_COL(REGS_PER_COL)) u_cls (
    .src_rdy_i  (src_rdy_i),
    .src0_tag_i (src0_tag_i),
    .src1_tag_i (src1_tag_i),
    .kind_o     (kind),
    .wait_tag_o (wait_tag_o),
    .dep_col_o  (dep_col)
  );

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    assign push[c]  = free_valid_i && (int'(free_tag_i[TAG_W-1:LW]) == c);
    assign pop[c]   = disp_fire_o && (int'(col) == c);
    assign avail[c] = !empty[c] && !win_full_i[c];
    steer_free_list #(.REGS_PER_COL(REGS_PER_COL)) u_fl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pop_i      (pop[c]),
      .push_i     (push[c]),
      .push_idx_i (free_tag_i[LW-1:0]),
      .empty_o    (empty[c]),
      .head_o     (head_all[c]),
      .cnt_o      (cnt_all[c])
    );
  end

  steer_rr_pick #(.NUM_COLS(NUM_COLS)) u_rr (
    .avail_i (avail),
    .start_i (rr_q),
    .found_o (rr_found),
    .pick_o  (rr_pick)
  );

  always_comb begin
    unique case (kind)
      KIND_READY: begin col = rr_pick; ok = rr_found;       end
      KIND_DEP:   begin col = dep_col; ok = avail[dep_col]; end
      default:    begin col = '0;      ok = 1'b0;           end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (disp_fire_o && kind == KIND_READY)
      rr_q <= (int'(col) == NUM_COLS - 1) ? '0 : col + 1'b1;
  end

  assign disp_fire_o  = disp_valid_i && ok;
  assign stall_o      = disp_valid_i && !ok;
  assign disp_col_o   = col;
  assign disp_dst_o   = {col, head_all[col]};
  assign wait_valid_o = disp_valid_i && (kind == KIND_DEP);
endmodule

// File: rtl/col_steer_chk.sv
module col_steer_chk #(
  parameter int NUM_COLS     = 4,
  parameter int REGS_PER_COL = 8,
  localparam int COL_W = $clog2(NUM_COLS),
  localparam int LW    = $clog2(REGS_PER_COL),
  localparam int TAG_W = COL_W + LW
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                disp_valid_i,
  input logic [1:0]          src_rdy_i,
  input logic [TAG_W-1:0]    src0_tag_i,
  input logic [TAG_W-1:0]    src1_tag_i,
  input logic [NUM_COLS-1:0] win_full_i,
  input logic                disp_fire_o,
  input logic                stall_o,
  input logic [COL_W-1:0]    disp_col_o,
  input logic [TAG_W-1:0]    disp_dst_o,
  input logic                wait_valid_o,
  input logic [TAG_W-1:0]    wait_tag_o
);
  logic [COL_W-1:0] ring_next;
  assign ring_next = (int'(wait_tag_o[TAG_W-1:LW]) == NUM_COLS - 1) ? '0
                   : wait_tag_o[TAG_W-1:LW] + 1'b1;

  p_bank_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_fire_o |-> disp_dst_o[TAG_W-1:LW] == disp_col_o);
  p_ring_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_fire_o && wait_valid_o) |-> disp_col_o == ring_next);
  p_two_wait_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_i && src_rdy_i == 2'b00) |-> (stall_o && !disp_fire_o));
  p_win_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_fire_o |-> !win_full_i[disp_col_o]);
  p_wait_tag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_i && src_rdy_i == 2'b10) |-> (wait_valid_o && wait_tag_o == src0_tag_i));
  p_no_wait_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_i && src_rdy_i == 2'b11) |-> !wait_valid_o);
  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_valid_i |-> (!disp_fire_o && !stall_o));
  p_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(disp_fire_o && stall_o));
endmodule

bind col_steer col_steer_chk #(.NUM_COLS(NUM_COLS), .REGS_PER_COL(REGS_PER_COL)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .disp_valid_i (disp_valid_i),
  .src_rdy_i    (src_rdy_i),
  .src0_tag_i   (src0_tag_i),
  .src1_tag_i   (src1_tag_i),
  .win_full_i   (win_full_i),
  .disp_fire_o  (disp_fire_o),
  .stall_o      (stall_o),
  .disp_col_o   (disp_col_o),
  .disp_dst_o   (disp_dst_o),
  .wait_valid_o (wait_valid_o),
  .wait_tag_o   (wait_tag_o)
);

// File: tb/col_steer_tb.sv
module col_steer_tb;
  localparam int CLK_P = 10;
  localparam int NC = 4;
  localparam int RC = 8;

  typedef struct packed {
    logic       vld;
    logic [1:0] rdy;
    logic [4:0] t0;
    logic [4:0] t1;
    logic [3:0] wf;
    logic       fv;
    logic [4:0] ft;
    logic       e_fire;
    logic       e_stall;
    logic [1:0] e_col;
    logic [4:0] e_dst;
    logic       e_wv;
    logic [4:0] e_wt;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'b11, 5'd0,  5'd0,  4'b0000, 1'b0, 5'd0, 1'b1, 1'b0, 2'd0, 5'd0,  1'b0, 5'd0},
    '{1'b1, 2'b11, 5'd0,  5'd0,  4'b0000, 1'b0, 5'd0, 1'b1, 1'b0, 2'd1, 5'd8,  1'b0, 5'd0},
    '{1'b1, 2'b10, 5'd8,  5'd0,  4'b0000, 1'b0, 5'd0, 1'b1, 1'b0, 2'd2, 5'd16, 1'b1, 5'd8},
    '{1'b1, 2'b01, 5'd0,  5'd31, 4'b0000, 1'b0, 5'd0, 1'b1, 1'b0, 2'd0, 5'd1,  1'b1, 5'd31},
    '{1'b1, 2'b00, 5'd3,  5'd4,  4'b0000, 1'b0, 5'd0, 1'b0, 1'b1, 2'd0, 5'd0,  1'b0, 5'd0},
    '{1'b1, 2'b11, 5'd0,  5'd0,  4'b0100, 1'b0, 5'd0, 1'b1, 1'b0, 2'd3, 5'd24, 1'b0, 5'd0},
    '{1'b1, 2'b10, 5'd5,  5'd0,  4'b0010, 1'b0, 5'd0, 1'b0, 1'b1, 2'd0, 5'd0,  1'b1, 5'd5},
    '{1'b0, 2'b11, 5'd0,  5'd0,  4'b0000, 1'b1, 5'd0, 1'b0, 1'b0, 2'd0, 5'd0,  1'b0, 5'd0}
  };
  localparam string VREQ [NV] = '{"R7", "R4", "R2", "R2", "R3", "R4", "R5", "R9"};

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       disp_valid_i = 1'b0;
  logic [1:0] src_rdy_i = 2'b11;
  logic [4:0] src0_tag_i = '0, src1_tag_i = '0, free_tag_i = '0;
  logic [3:0] win_full_i = '0;
  logic       free_valid_i = 1'b0;
  logic       disp_fire_o, stall_o, wait_valid_o;
  logic [1:0] disp_col_o;
  logic [4:0] disp_dst_o, wait_tag_o;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  col_steer #(.NUM_COLS(NC), .REGS_PER_COL(RC)) u_dut (
    .clk_i, .rst_ni, .disp_valid_i, .src_rdy_i, .src0_tag_i, .src1_tag_i,
    .win_full_i, .free_valid_i, .free_tag_i, .disp_fire_o, .stall_o,
    .disp_col_o, .disp_dst_o, .wait_valid_o, .wait_tag_o
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v, input string req);
    @(negedge clk_i);
    disp_valid_i = v.vld; src_rdy_i = v.rdy; src0_tag_i = v.t0; src1_tag_i = v.t1;
    win_full_i = v.wf; free_valid_i = v.fv; free_tag_i = v.ft;
    #(CLK_P/4);
    chk(req, "fire", int'(disp_fire_o), int'(v.e_fire));
    chk(req, "stall", int'(stall_o), int'(v.e_stall));
    chk("R8", "wait_valid", int'(wait_valid_o), int'(v.e_wv));
    if (v.e_fire) begin
      chk(req, "col", int'(disp_col_o), int'(v.e_col));
      chk(req, "dst", int'(disp_dst_o), int'(v.e_dst));
    end
    if (v.e_wv) chk("R8", "wait_tag", int'(wait_tag_o), int'(v.e_wt));
  endtask

  function automatic vec_t mk(input logic vld, input logic [1:0] rdy, input logic [4:0] t0,
                              input logic [3:0] wf, input logic fv, input logic [4:0] ft,
                              input logic ef, input logic es, input logic [1:0] ec,
                              input logic [4:0] ed);
    vec_t v;
    v.vld = vld; v.rdy = rdy; v.t0 = t0; v.t1 = 5'd0; v.wf = wf; v.fv = fv; v.ft = ft;
    v.e_fire = ef; v.e_stall = es; v.e_col = ec; v.e_dst = ed;
    v.e_wv = vld && (rdy == 2'b10); v.e_wt = t0;
    return v;
  endfunction

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk("R7", "reset fire", int'(disp_fire_o), 0);
    chk("R9", "reset stall", int'(stall_o), 0);
    @(negedge clk_i) rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) apply(VECS[i], VREQ[i]);

    // R6: bank 0 slots 2..7, then returned tag 0 comes last (producer in bank 3 -> column 0)
    for (int k = 0; k < 7; k++)
      apply(mk(1'b1, 2'b10, 5'd24, 4'b0, 1'b0, 5'd0, 1'b1, 1'b0, 2'd0,
               (k < 6) ? 5'(k + 2) : 5'd0), "R6");
    // R5: bank 0 now empty
    apply(mk(1'b1, 2'b10, 5'd24, 4'b0, 1'b0, 5'd0, 1'b0, 1'b1, 2'd0, 5'd0), "R5");
    // R4: pointer at 0, column 0 empty -> column 1, slot 1 of bank 1
    apply(mk(1'b1, 2'b11, 5'd0, 4'b0, 1'b0, 5'd0, 1'b1, 1'b0, 2'd1, 5'd9), "R4");
    // R6: return in the same cycle does not rescue the stall
    apply(mk(1'b1, 2'b10, 5'd24, 4'b0, 1'b1, 5'd3, 1'b0, 1'b1, 2'd0, 5'd0), "R6");
    apply(mk(1'b1, 2'b10, 5'd24, 4'b0, 1'b0, 5'd0, 1'b1, 1'b0, 2'd0, 5'd3), "R6");
    // R4: every window slice full
    apply(mk(1'b1, 2'b11, 5'd0, 4'b1111, 1'b0, 5'd0, 1'b0, 1'b1, 2'd0, 5'd0), "R4");
    // R4: pointer advanced to 2 after column 1
    apply(mk(1'b1, 2'b11, 5'd0, 4'b0, 1'b0, 5'd0, 1'b1, 1'b0, 2'd2, 5'd17), "R4");
    // R1: dependent on bank 1 -> column 2 stays in bank 2
    apply(mk(1'b1, 2'b10, 5'd12, 4'b0, 1'b0, 5'd0, 1'b1, 1'b0, 2'd2, 5'd18), "R1");

    // R7: reset restores full banks and pointer
    @(negedge clk_i);
    disp_valid_i = 1'b0; free_valid_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i) rst_ni = 1'b1;
    apply(mk(1'b1, 2'b11, 5'd0, 4'b0, 1'b0, 5'd0, 1'b1, 1'b0, 2'd0, 5'd0), "R7");
    apply(mk(1'b1, 2'b10, 5'd24, 4'b0, 1'b0, 5'd0, 1'b1, 1'b0, 2'd0, 5'd1), "R7");

    @(negedge clk_i) disp_valid_i = 1'b0;
    finish_run();
  end
endmodule